// File: doc/BRIEF.md
# Temporal Implication Checker with Modes

This block is a synthesizable monitor that watches two single-bit event inputs and enforces the rule that every antecedent event must be followed by a consequent event between `MIN_DLY` and `MAX_DLY` cycles later. The offset is counted from the antecedent's own cycle, so the implication adds no delay of its own. When an attempt passes its window without a qualifying consequent, the monitor raises a one-cycle `fire` pulse. A fixed severity code is driven with that pulse.

A three-bit `mode` input sets what happens when a new antecedent arrives while earlier attempts are still open. Three modes keep a single attempt: the new one replaces it, is dropped silently, or is dropped and reported. Two modes keep one attempt per antecedent, held as a small queue of age counters, oldest first. In one of these a consequent discharges every attempt in its window. In the other it discharges only the oldest one. The queue depth, the window bounds, the severity, the reset polarity, synchronous or asynchronous reset, and the active clock edge are all build-time parameters. It is intended to be instantiated next to the logic it observes.

Top module: `impl_window_check`

## Requirements
- R1: While reset is active, and at the first active clock edge after it is released, `fire`, `severity`, `restart_rpt` and `overflow` are 0. Antecedents seen during reset leave no open attempt behind.
- R2: An antecedent at cycle t is satisfied by a consequent at cycle t+k when MIN_DLY <= k <= MAX_DLY. A consequent with k < MIN_DLY does not count. An unsatisfied attempt makes `fire` high for exactly cycle t+MAX_DLY+1.
- R3: With MIN_DLY = 0, a consequent in the same cycle as the antecedent satisfies that attempt.
- R4: `severity` equals the SEVERITY parameter while `fire` is high, and 0 otherwise. The encoding is 0 info, 1 warning, 2 error, 3 fatal.
- R5: Mode 0 (restart), and also the unused codes 5 to 7: an antecedent silently drops any open attempt, which never fires, and opens a new one.
- R6: Mode 1 (keep first): an antecedent that arrives while an attempt is open is ignored, and no output shows it.
- R7: Mode 2 (keep first and report): such an antecedent is ignored, and `restart_rpt` is high for the following cycle. It is low in all other modes.
- R8: Mode 3 (overlap): every antecedent opens its own attempt. One consequent satisfies every open attempt whose age is at least MIN_DLY.
- R9: Mode 4 (pipe): every antecedent opens its own attempt. One consequent satisfies only the oldest open attempt whose age is at least MIN_DLY.
- R10: In modes 3 and 4, an antecedent that arrives when DEPTH attempts are open at the start of its cycle is dropped, and `overflow` is high for the following cycle.
- R11: RST_ACTIVE_LOW selects reset polarity and RST_SYNC selects a synchronous or asynchronous reset. With RST_SYNC = 0, outputs clear as soon as reset asserts. FALL_EDGE = 1 moves all state changes to the falling clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; active edge chosen by FALL_EDGE |
| rst | input | 1 | Reset; polarity and synchronism set by parameters |
| mode | input | 3 | Execution mode: 0 restart, 1 keep first, 2 keep first and report, 3 overlap, 4 pipe |
| ante | input | 1 | Antecedent event, one per cycle at most |
| cons | input | 1 | Consequent event |
| fire | output | 1 | One-cycle pulse when an attempt's window closes unsatisfied |
| severity | output | 2 | Severity code, driven with `fire` |
| restart_rpt | output | 1 | Pulse for an ignored antecedent in mode 2 |
| overflow | output | 1 | Pulse for an antecedent dropped because the queue was full |

## Verification
The awkward coincidence is a new antecedent arriving at a full queue in the same cycle that the oldest attempt expires or is discharged. The antecedent is still dropped with `overflow`, because fullness is judged at the start of the cycle. The same applies in the single-attempt modes: an antecedent in the cycle where the open attempt closes still counts as arriving while it runs. Dense pseudo-random antecedent streams in the queued modes fill the queue and create these coincidences many times. A cycle-level model in the bench judges every output each cycle, and separate directed sequences cover the zero-offset case and the asynchronous, active-low, falling-edge build.

// File: rtl/impl_window_check.sv
module impl_window_check #(
  parameter int MIN_DLY        = 2,
  parameter int MAX_DLY        = 4,
  parameter int DEPTH          = 3,
  parameter int SEVERITY       = 2,
  parameter int RST_ACTIVE_LOW = 0,
  parameter int RST_SYNC       = 1,
  parameter int FALL_EDGE      = 0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] mode,
  input  logic       ante,
  input  logic       cons,
  output logic       fire,
  output logic [1:0] severity,
  output logic       restart_rpt,
  output logic       overflow
);
  localparam int AW = $clog2(MAX_DLY + 1);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [1:0] SEV2 = SEVERITY[1:0];

  logic          ck, rst_on;
  logic [AW-1:0] age   [DEPTH];
  logic [AW-1:0] age_n [DEPTH];
  logic [CW-1:0] cnt, cnt_n;
  logic          fire_q, rpt_q, ovf_q;
  logic          fire_n, rpt_n, ovf_n;
  logic          is_ovl, is_pipe, is_multi, is_nr, is_rr, is_rs;
  logic          accept, new_sat, push;
  int            nq, cpop, npop, rem;

  assign ck     = (FALL_EDGE != 0) ? ~clk : clk;
  assign rst_on = (RST_ACTIVE_LOW != 0) ? ~rst : rst;

  assign is_ovl   = (mode == 3'd3);
  assign is_pipe  = (mode == 3'd4);
  assign is_multi = is_ovl | is_pipe;
  assign is_nr    = (mode == 3'd1);
  assign is_rr    = (mode == 3'd2);
  assign is_rs    = ~(is_multi | is_nr | is_rr);

  always_comb begin
    nq = 0;
    for (int i = 0; i < DEPTH; i++)
      if (i < int'(cnt) && int'(age[i]) >= MIN_DLY) nq = nq + 1;
    cpop   = 0;
    fire_n = 1'b0;
    if (is_rs && ante) begin
      npop = int'(cnt);
    end else begin
      if (cons) cpop = is_ovl ? nq : ((cnt != '0 && int'(age[0]) >= MIN_DLY) ? 1 : 0);
      npop = cpop;
      if (cpop == 0 && cnt != '0 && int'(age[0]) == MAX_DLY) begin
        fire_n = 1'b1;
        npop   = 1;
      end
    end
    accept  = ante && (is_multi ? (int'(cnt) < DEPTH) : (is_rs || cnt == '0));
    new_sat = cons && (MIN_DLY == 0) && !(is_pipe && cpop != 0);
    push    = accept && !new_sat;
    ovf_n   = ante && is_multi && (int'(cnt) == DEPTH);
    rpt_n   = ante && is_rr && (cnt != '0);
    rem     = int'(cnt) - npop;

    age_n = age;
    for (int s = 0; s < DEPTH; s++) begin
      if (s < npop) begin
        for (int i = 0; i < DEPTH - 1; i++) age_n[i] = age_n[i+1];
        age_n[DEPTH-1] = '0;
      end
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (i < rem)                   age_n[i] = age_n[i] + AW'(1);
      else if (push && i == rem)     age_n[i] = AW'(1);
      else                           age_n[i] = '0;
    end
    cnt_n = CW'(rem + (push ? 1 : 0));
  end

  generate
    if (RST_SYNC != 0) begin : g_sync
      always_ff @(posedge ck) begin
        if (rst_on) begin
          age <= '{default: '0}; cnt <= '0;
          fire_q <= 1'b0; rpt_q <= 1'b0; ovf_q <= 1'b0;
        end else begin
          age <= age_n; cnt <= cnt_n;
          fire_q <= fire_n; rpt_q <= rpt_n; ovf_q <= ovf_n;
        end
      end
    end else begin : g_async
      always_ff @(posedge ck or posedge rst_on) begin
        if (rst_on) begin
          age <= '{default: '0}; cnt <= '0;
          fire_q <= 1'b0; rpt_q <= 1'b0; ovf_q <= 1'b0;
        end else begin
          age <= age_n; cnt <= cnt_n;
          fire_q <= fire_n; rpt_q <= rpt_n; ovf_q <= ovf_n;
        end
      end
    end
  endgenerate

  assign fire        = fire_q;
  assign severity    = fire_q ? SEV2 : 2'b00;
  assign restart_rpt = rpt_q;
  assign overflow    = ovf_q;

  p_cnt_bound_r10: assert property (@(posedge ck) disable iff (rst_on)
    int'(cnt) <= DEPTH);
  p_ovf_cause_r10: assert property (@(posedge ck) disable iff (rst_on)
    overflow |-> ($past(ante) && $past(is_multi)));
  p_rpt_cause_r7: assert property (@(posedge ck) disable iff (rst_on)
    restart_rpt |-> ($past(ante) && $past(mode) == 3'd2 && $past(cnt) != '0));
  p_fire_pending_r2: assert property (@(posedge ck) disable iff (rst_on)
    fire |-> ($past(cnt) != '0));
  p_restart_r5: assert property (@(posedge ck) disable iff (rst_on)
    (MIN_DLY != 0 && is_rs && ante) |=> (cnt == CW'(1)));
endmodule

// File: tb/impl_window_check_test.sv
`timescale 1ns/1ps
module impl_window_check_test;
  localparam int BMIN = 2, BMAX = 4, BDEPTH = 3, BSEV = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst, ante, cons;
  logic [2:0] mode;
  logic       fire, rpt, ovf;
  logic [1:0] sev;

  impl_window_check #(.MIN_DLY(BMIN), .MAX_DLY(BMAX), .DEPTH(BDEPTH), .SEVERITY(BSEV),
    .RST_ACTIVE_LOW(0), .RST_SYNC(1), .FALL_EDGE(0)) uut (
    .clk(clk), .rst(rst), .mode(mode), .ante(ante), .cons(cons),
    .fire(fire), .severity(sev), .restart_rpt(rpt), .overflow(ovf));

  logic       zrstn, za, zc;
  logic       zfire, zrpt, zovf;
  logic [1:0] zsev;

  impl_window_check #(.MIN_DLY(0), .MAX_DLY(1), .DEPTH(2), .SEVERITY(3),
    .RST_ACTIVE_LOW(1), .RST_SYNC(0), .FALL_EDGE(1)) uut_z (
    .clk(clk), .rst(zrstn), .mode(3'd3), .ante(za), .cons(zc),
    .fire(zfire), .severity(zsev), .restart_rpt(zrpt), .overflow(zovf));

  int checks = 0, errors = 0;
  int q[0:7];
  int qc = 0;
  logic efire = 0, erpt = 0, eovf = 0;
  string mtag = "R5";

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", what, act, exp, $time);
    end
  endtask

  task automatic pop();
    for (int i = 0; i < 7; i++) q[i] = q[i+1];
    qc--;
  endtask

  task automatic model(input logic a, input logic c);
    int start;
    bit cused, acc, rs;
    efire = 0; erpt = 0; eovf = 0; cused = 0; acc = 0;
    start = qc;
    rs = !(mode >= 3'd1 && mode <= 3'd4);
    if (a && rs) qc = 0;
    else begin
      if (c) begin
        if (mode == 3'd3) begin
          while (qc > 0 && q[0] >= BMIN) begin pop(); cused = 1; end
        end else if (qc > 0 && q[0] >= BMIN) begin
          pop(); cused = 1;
        end
      end
      if (!cused && qc > 0 && q[0] == BMAX) begin pop(); efire = 1; end
    end
    if (a) begin
      if (mode == 3'd3 || mode == 3'd4) begin
        if (start == BDEPTH) eovf = 1; else acc = 1;
      end else if (mode == 3'd1 || mode == 3'd2) begin
        if (start > 0) erpt = (mode == 3'd2); else acc = 1;
      end else acc = 1;
    end
    if (acc && !(c && BMIN == 0 && !(mode == 3'd4 && cused))) begin q[qc] = 0; qc++; end
    for (int i = 0; i < qc; i++) q[i]++;
  endtask

  task automatic mstep(input logic a, input logic c);
    @(negedge clk);
    check(fire === efire, {"R2 ", mtag, " fire"}, int'(fire), int'(efire));
    check(sev === (efire ? 2'(BSEV) : 2'd0), "R4 severity", int'(sev), efire ? BSEV : 0);
    check(rpt === erpt, "R7 restart report", int'(rpt), int'(erpt));
    check(ovf === eovf, "R10 overflow", int'(ovf), int'(eovf));
    ante = a; cons = c;
    model(a, c);
  endtask

  task automatic do_reset(input logic a_during);
    @(negedge clk);
    rst = 1; ante = a_during; cons = 0;
    repeat (3) @(negedge clk);
    check({fire, rpt, ovf, sev} === 5'b0, "R1 outputs in reset", int'({fire, rpt, ovf, sev}), 0);
    rst = 0; ante = 0; cons = 0;
    qc = 0; efire = 0; erpt = 0; eovf = 0;
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  logic [15:0] lf = 16'hACE1;

  initial begin
    rst = 1; ante = 0; cons = 0; mode = 3'd3;
    zrstn = 0; za = 0; zc = 0;

    // R1: antecedents during reset leave nothing pending
    do_reset(1'b1);
    for (int k = 0; k < BMAX + 3; k++) begin
      @(negedge clk);
      check({fire, rpt, ovf, sev} === 5'b0, "R1 outputs after reset", int'({fire, rpt, ovf, sev}), 0);
    end

    // R2: early consequent ignored, window edge hits
    mtag = "R8"; mode = 3'd3; do_reset(1'b0);
    mstep(1, 0); mstep(0, 1); mstep(0, 0); mstep(0, 0); mstep(0, 0); mstep(0, 0);
    mstep(0, 0); mstep(1, 0); mstep(0, 0); mstep(0, 0); mstep(0, 0); mstep(0, 1);
    mstep(0, 0); mstep(0, 0); mstep(0, 0);

    // sweeps per mode (R5 R6 R7 R8 R9 R10)
    for (int m = 0; m < 6; m++) begin
      mode = (m == 5) ? 3'd6 : 3'(m);
      mtag = (m == 1) ? "R6" : (m == 2) ? "R7" : (m == 3) ? "R8" : (m == 4) ? "R9" : "R5";
      do_reset(1'b0);
      for (int k = 0; k < 700; k++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        mstep(lf[0] | (m >= 3 && lf[9]), lf[4] & lf[7]);
      end
      repeat (BMAX + 2) mstep(0, 0);
    end

    // R3 R11 R4: zero-offset, active-low asynchronous, falling-edge instance
    @(posedge clk); #1 zrstn = 1;
    @(posedge clk); #1 za = 1; zc = 1;
    @(posedge clk); #1 za = 0; zc = 0;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      check(zfire === 1'b0, "R3 same-cycle consequent", int'(zfire), 0);
    end
    za = 1;
    @(posedge clk); #1 za = 0;
    check(zfire === 1'b0, "R11 falling edge fire not yet", int'(zfire), 0);
    @(posedge clk); #1;
    check(zfire === 1'b1, "R11 falling edge fire", int'(zfire), 1);
    check(zsev === 2'd3, "R4 fatal severity", int'(zsev), 3);
    #1 zrstn = 0; #0.5;
    check(zfire === 1'b0, "R11 asynchronous clear", int'(zfire), 0);
    check(zsev === 2'd0, "R11 severity cleared", int'(zsev), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule